// File: doc/BRIEF.md
# Flash Embedded-Operation Error Flags

This block sits beside the embedded program and erase engine of a NOR flash device. It produces the two error bits of the status byte that the host polls: the timing-limit bit (bit 5) and the buffer-abort bit (bit 1). It also reports whether the running operation has stalled on an illegal program, whether an operation is in flight, and which read mode the device falls back to once an operation ends or its failure is cleared.

An operation begins with a start strobe and a kind code (program, erase or write-to-buffer). The engine's internal program/erase pulse tick advances a counter. If the counter reaches the parameter `PULSE_LIMIT` before the engine signals completion, the timing-limit bit sets. A program that asks for any bit to go from 0 to 1 cannot succeed, because only erase raises bits. Such a program is halted at once and keeps counting pulses until the limit sets bit 5. Decoded reset commands come from the external command decoder. Each one is honoured only in the fault state it belongs to. The mode after recovery depends on what the device was doing when the operation started.

Top module: `flash_err_flags`

## Requirements
- R1: During and right after reset, `st_timeout` and `st_abort` are 0, `busy` and `halted` are 0, and `resume_mode` is 0 (array read).
- R2: While an operation is in flight, `st_timeout` rises in the cycle after the `PULSE_LIMIT`-th `pulse_tick` counted since its start, and not earlier. This holds for program, erase and write-to-buffer alike.
- R3: A start with `op_kind`=0 (program) where some bit has `prog_old`=0 and `prog_new`=1 sets `halted` in the next cycle. While halted, `op_done` has no effect, and the operation ends only through the timing limit of R2.
- R4: A program that only clears bits, and any erase (`op_kind`=1, or reserved code 3) or write-to-buffer (`op_kind`=2), runs with `halted`=0. An `op_done` before the limit returns the block to idle with both error bits 0.
- R5: `st_timeout` and `st_abort` are 0 while idle and during any operation that has not failed. They are never both 1.
- R6: After a timing-limit failure of an operation started with `bypass_mode`=0, only `cmd_reset` clears bit 5 and returns to idle. `cmd_bypass_reset` and `cmd_abort_reset` are ignored.
- R7: After a timing-limit failure of an operation started with `bypass_mode`=1, only `cmd_bypass_reset` clears bit 5. `cmd_reset` and `cmd_abort_reset` are ignored.
- R8: When an operation ends by `op_done`, or its bit-5 failure is cleared, `resume_mode` becomes the value `susp_prog` had at its start: 1 means erase-suspend-read and 0 means array read.
- R9: `wbuf_abort` during a write-to-buffer operation sets `st_abort` in the next cycle, taking priority over `op_done` and the pulse limit. During program or erase it is ignored.
- R10: Once set, `st_abort` is cleared only by `cmd_abort_reset`, which also sets `resume_mode` to 0. `cmd_reset` and `cmd_bypass_reset` leave it set.
- R11: `op_start` is ignored unless the block is idle. It does not restart the counter or change the operation kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Start strobe for an embedded operation |
| op_kind | input | 2 | 0 program, 1 erase, 2 write-to-buffer, 3 treated as erase |
| prog_old | input | DATA_W | Current stored word at the program target |
| prog_new | input | DATA_W | Word requested by the program |
| susp_prog | input | 1 | Device is in erase-suspend-program at start |
| bypass_mode | input | 1 | Device is in unlock-bypass at start |
| pulse_tick | input | 1 | One internal program/erase pulse |
| op_done | input | 1 | Engine reports successful completion |
| wbuf_abort | input | 1 | Write-to-buffer abort event |
| cmd_reset | input | 1 | Decoded ordinary reset command |
| cmd_bypass_reset | input | 1 | Decoded unlock-bypass reset command |
| cmd_abort_reset | input | 1 | Decoded buffer-abort reset command |
| st_timeout | output | 1 | Status bit 5, timing limit exceeded |
| st_abort | output | 1 | Status bit 1, write-to-buffer aborted |
| halted | output | 1 | Program halted on a 0-to-1 request |
| busy | output | 1 | Operation in flight (running or halted) |
| resume_mode | output | 1 | Read mode after exit: 0 array, 1 erase-suspend-read |

## Verification
Program words are drawn in two ways. One is clearing-only, where the new word is the old word masked. The other is fully random, which almost always requests some 0-to-1 change. These two separate the normal run path from the halt path. Reset commands of all three kinds arrive at random in every state, so a fault cleared by the wrong command stands out against the bench model. Operations start with `bypass_mode` and `susp_prog` set either way, which separates the two recovery rules from each other and from the recovery mode. Directed cases place the timing limit exactly on and one tick before `PULSE_LIMIT`, and let `wbuf_abort` and `op_done` collide in the same cycle.

// File: rtl/flash_err_pkg.sv
package flash_err_pkg;

   typedef enum logic [1:0] {
      OPK_PROG  = 2'd0,
      OPK_ERASE = 2'd1,
      OPK_WBUF  = 2'd2,
      OPK_RSVD  = 2'd3
   } op_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_HALT  = 3'd2,
      ST_FAIL  = 3'd3,
      ST_ABORT = 3'd4
   } err_state_e;

   localparam logic MODE_ARRAY    = 1'b0;
   localparam logic MODE_SUSPREAD = 1'b1;

endpackage

// File: rtl/flash_prog_check.sv
module flash_prog_check #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   output logic              raise_req
);
   logic [DATA_W-1:0] raise_bits;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         assign raise_bits[b] = ~old_word[b] & new_word[b];
      end
   endgenerate

   assign raise_req = |raise_bits;
endmodule

// File: rtl/flash_pulse_cnt.sv
module flash_pulse_cnt #(
   parameter int LIMIT = 64,
   parameter int CNT_W = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic limit_hit
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   assign limit_hit = step && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step && (cnt_q != LAST)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/flash_err_fsm.sv
module flash_err_fsm
   import flash_err_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_start,
   input  logic [1:0] op_kind,
   input  logic       raise_req,
   input  logic       susp_prog,
   input  logic       bypass_mode,
   input  logic       limit_hit,
   input  logic       op_done,
   input  logic       wbuf_abort,
   input  logic       cmd_reset,
   input  logic       cmd_bypass_reset,
   input  logic       cmd_abort_reset,
   output err_state_e state,
   output logic       resume_mode
);
   err_state_e st_q, st_n;
   op_kind_e   kind_q, kind_n;
   logic       susp_q, susp_n;
   logic       byp_q, byp_n;
   logic       mode_q, mode_n;
   logic       clear_ok;

   assign clear_ok = byp_q ? cmd_bypass_reset : cmd_reset;

   always_comb begin
      st_n   = st_q;
      kind_n = kind_q;
      susp_n = susp_q;
      byp_n  = byp_q;
      mode_n = mode_q;
      unique case (st_q)
         ST_IDLE: begin
            if (op_start) begin
               kind_n = op_kind_e'(op_kind);
               susp_n = susp_prog;
               byp_n  = bypass_mode;
               if ((op_kind_e'(op_kind) == OPK_PROG) && raise_req)
                  st_n = ST_HALT;
               else
                  st_n = ST_RUN;
            end
         end
         ST_RUN: begin
            if ((kind_q == OPK_WBUF) && wbuf_abort) begin
               st_n = ST_ABORT;
            end else if (op_done) begin
               st_n   = ST_IDLE;
               mode_n = susp_q;
            end else if (limit_hit) begin
               st_n = ST_FAIL;
            end
         end
         ST_HALT: begin
            if (limit_hit) st_n = ST_FAIL;
         end
         ST_FAIL: begin
            if (clear_ok) begin
               st_n   = ST_IDLE;
               mode_n = susp_q;
            end
         end
         ST_ABORT: begin
            if (cmd_abort_reset) begin
               st_n   = ST_IDLE;
               mode_n = MODE_ARRAY;
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= OPK_ERASE;
         susp_q <= 1'b0;
         byp_q  <= 1'b0;
         mode_q <= MODE_ARRAY;
      end else begin
         st_q   <= st_n;
         kind_q <= kind_n;
         susp_q <= susp_n;
         byp_q  <= byp_n;
         mode_q <= mode_n;
      end
   end

   assign state       = st_q;
   assign resume_mode = mode_q;
endmodule

// File: rtl/flash_err_flags.sv
module flash_err_flags
   import flash_err_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int PULSE_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start,
   input  logic [1:0]        op_kind,
   input  logic [DATA_W-1:0] prog_old,
   input  logic [DATA_W-1:0] prog_new,
   input  logic              susp_prog,
   input  logic              bypass_mode,
   input  logic              pulse_tick,
   input  logic              op_done,
   input  logic              wbuf_abort,
   input  logic              cmd_reset,
   input  logic              cmd_bypass_reset,
   input  logic              cmd_abort_reset,
   output logic              st_timeout,
   output logic              st_abort,
   output logic              halted,
   output logic              busy,
   output logic              resume_mode
);
   localparam int CNT_W = (PULSE_LIMIT < 2) ? 1 : $clog2(PULSE_LIMIT);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("flash_err_flags: DATA_W must be at least 1");
      end
      if (PULSE_LIMIT < 2) begin : g_bad_limit
         $error("flash_err_flags: PULSE_LIMIT must be at least 2");
      end
   endgenerate

   logic       raise_req;
   logic       limit_hit;
   logic       in_flight;
   err_state_e state;

   flash_prog_check #(.DATA_W(DATA_W)) u_check (
      .old_word  (prog_old),
      .new_word  (prog_new),
      .raise_req (raise_req)
   );

   assign in_flight = (state == ST_RUN) || (state == ST_HALT);

   flash_pulse_cnt #(.LIMIT(PULSE_LIMIT), .CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state == ST_IDLE),
      .step      (pulse_tick && in_flight),
      .limit_hit (limit_hit)
   );

   flash_err_fsm u_fsm (
      .clk              (clk),
      .rst_n            (rst_n),
      .op_start         (op_start),
      .op_kind          (op_kind),
      .raise_req        (raise_req),
      .susp_prog        (susp_prog),
      .bypass_mode      (bypass_mode),
      .limit_hit        (limit_hit),
      .op_done          (op_done),
      .wbuf_abort       (wbuf_abort),
      .cmd_reset        (cmd_reset),
      .cmd_bypass_reset (cmd_bypass_reset),
      .cmd_abort_reset  (cmd_abort_reset),
      .state            (state),
      .resume_mode      (resume_mode)
   );

   assign st_timeout = (state == ST_FAIL);
   assign st_abort   = (state == ST_ABORT);
   assign halted     = (state == ST_HALT);
   assign busy       = in_flight;
endmodule

// File: rtl/flash_err_flags_chk.sv
module flash_err_flags_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       op_start,
   input logic [1:0] op_kind,
   input logic       wbuf_abort,
   input logic       cmd_reset,
   input logic       cmd_bypass_reset,
   input logic       cmd_abort_reset,
   input logic       st_timeout,
   input logic       st_abort,
   input logic       halted,
   input logic       busy
);
   a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_timeout && st_abort));

   a_r2_timeout_from_flight: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_timeout) |-> $past(busy));

   a_r3_halt_from_program: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> ($past(op_start) && ($past(op_kind) == 2'd0)));

   a_r9_abort_from_event: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_abort) |-> ($past(wbuf_abort) && $past(busy)));

   a_r10_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st_abort && !cmd_abort_reset) |=> st_abort);

   a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (st_timeout && !cmd_reset && !cmd_bypass_reset) |=> st_timeout);

   a_r11_no_start_when_faulted: assert property (@(posedge clk) disable iff (!rst_n)
      (st_timeout && !cmd_reset && !cmd_bypass_reset) |=> !busy);
endmodule

bind flash_err_flags flash_err_flags_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .op_start         (op_start),
   .op_kind          (op_kind),
   .wbuf_abort       (wbuf_abort),
   .cmd_reset        (cmd_reset),
   .cmd_bypass_reset (cmd_bypass_reset),
   .cmd_abort_reset  (cmd_abort_reset),
   .st_timeout       (st_timeout),
   .st_abort         (st_abort),
   .halted           (halted),
   .busy             (busy)
);

// File: tb/flash_err_flags_tb.sv
module flash_err_flags_tb;
   localparam int DW  = 16;
   localparam int LIM = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_start = 0, susp_prog = 0, bypass_mode = 0;
   logic [1:0]    op_kind = 0;
   logic [DW-1:0] prog_old = 0, prog_new = 0;
   logic          pulse_tick = 0, op_done = 0, wbuf_abort = 0;
   logic          cmd_reset = 0, cmd_bypass_reset = 0, cmd_abort_reset = 0;
   logic          st_timeout, st_abort, halted, busy, resume_mode;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   // bench model: 0 idle, 1 run, 2 halt, 3 fail, 4 abort
   int   m_st = 0, m_cnt = 0;
   logic [1:0] m_kind = 2'd1;
   logic m_susp = 0, m_byp = 0, m_mode = 0;

   always #4 clk = ~clk;

   flash_err_flags #(.DATA_W(DW), .PULSE_LIMIT(LIM)) u_dut (.*);

   function automatic bit raises(logic [DW-1:0] o, logic [DW-1:0] n);
      return ((~o & n) != 0);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " timeout"}, st_timeout, m_st == 3);
      chk({tag, " abort"},   st_abort,   m_st == 4);
      chk({tag, " halted"},  halted,     m_st == 2);
      chk({tag, " busy"},    busy,       m_st == 1 || m_st == 2);
      chk({tag, " mode"},    resume_mode, m_mode);
   endtask

   // model advance from requirements, applied at each rising edge
   task automatic model_step();
      bit hit;
      hit = (m_st == 1 || m_st == 2) && pulse_tick && (m_cnt == LIM - 1);
      if ((m_st == 1 || m_st == 2) && pulse_tick && m_cnt < LIM - 1) m_cnt++;
      case (m_st)
         0: begin
            m_cnt = 0;
            if (op_start) begin
               m_kind = op_kind; m_susp = susp_prog; m_byp = bypass_mode;
               m_st = (op_kind == 2'd0 && raises(prog_old, prog_new)) ? 2 : 1;
            end
         end
         1: begin
            if (m_kind == 2'd2 && wbuf_abort) m_st = 4;
            else if (op_done) begin m_st = 0; m_mode = m_susp; end
            else if (hit) m_st = 3;
         end
         2: if (hit) m_st = 3;
         3: if (m_byp ? cmd_bypass_reset : cmd_reset) begin m_st = 0; m_mode = m_susp; end
         4: if (cmd_abort_reset) begin m_st = 0; m_mode = 1'b0; end
         default: m_st = 0;
      endcase
      if (m_st == 0) m_cnt = 0;
   endtask

   task automatic idle_inputs();
      op_start = 0; pulse_tick = 0; op_done = 0; wbuf_abort = 0;
      cmd_reset = 0; cmd_bypass_reset = 0; cmd_abort_reset = 0;
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check_all(tag);
      idle_inputs();
   endtask

   task automatic start_op(logic [1:0] k, logic [DW-1:0] o, logic [DW-1:0] n,
                           logic sp, logic bp, string tag);
      op_start = 1; op_kind = k; prog_old = o; prog_new = n;
      susp_prog = sp; bypass_mode = bp;
      cyc(tag);
   endtask

   task automatic ticks(int n, string tag);
      for (int i = 0; i < n; i++) begin
         pulse_tick = 1;
         cyc(tag);
      end
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check_all("R1 in reset");
      rst_n = 1;
      cyc("R1 after reset");

      // R4 clearing-only program, done before limit
      start_op(2'd0, 16'hF0F0, 16'hF000, 0, 0, "R4 start");
      ticks(LIM - 1, "R2 below limit");
      op_done = 1; cyc("R4 done");
      chk("R5 idle timeout", st_timeout, 1'b0);

      // R3 halted program, done ignored, timeout at exact limit
      start_op(2'd0, 16'h00FF, 16'h0100, 0, 0, "R3 start");
      chk("R3 halted", halted, 1'b1);
      op_done = 1; cyc("R3 done ignored");
      ticks(LIM - 1, "R2 one short");
      chk("R2 not yet", st_timeout, 1'b0);
      ticks(1, "R2 at limit");
      chk("R2 timeout set", st_timeout, 1'b1);
      // R11 start ignored while faulted; R6 wrong resets ignored
      start_op(2'd1, 0, 0, 0, 0, "R11 start ignored");
      cmd_bypass_reset = 1; cmd_abort_reset = 1; cyc("R6 wrong reset");
      chk("R6 still set", st_timeout, 1'b1);
      cmd_reset = 1; cyc("R6 cleared");
      chk("R6 cleared", st_timeout, 1'b0);

      // R7 bypass + R8 suspend recovery mode
      start_op(2'd1, 0, 0, 1, 1, "R7 erase start");
      ticks(LIM, "R7 run to limit");
      cmd_reset = 1; cyc("R7 plain reset ignored");
      chk("R7 still set", st_timeout, 1'b1);
      cmd_bypass_reset = 1; cyc("R7 bypass reset");
      chk("R8 suspend read", resume_mode, 1'b1);

      // R9 abort beats done; R10 sticky
      start_op(2'd2, 0, 0, 0, 0, "R9 wbuf start");
      start_op(2'd1, 0, 0, 0, 0, "R11 start while busy");
      ticks(3, "R9 running");
      wbuf_abort = 1; op_done = 1; cyc("R9 abort over done");
      chk("R9 abort set", st_abort, 1'b1);
      cmd_reset = 1; cmd_bypass_reset = 1; cyc("R10 other resets");
      chk("R10 still set", st_abort, 1'b1);
      cmd_abort_reset = 1; cyc("R10 abort reset");
      chk("R10 array mode", resume_mode, 1'b0);

      // R9 abort ignored for erase
      start_op(2'd3, 0, 0, 0, 0, "R4 reserved kind");
      wbuf_abort = 1; cyc("R9 ignored on erase");
      chk("R9 no abort", st_abort, 1'b0);
      op_done = 1; cyc("R4 erase done");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         op_start = ($urandom % 5) == 0;
         op_kind  = 2'($urandom % 4);
         prog_old = DW'($urandom);
         prog_new = ($urandom % 2) ? (prog_old & DW'($urandom)) : DW'($urandom);
         susp_prog   = $urandom % 2;
         bypass_mode = $urandom % 2;
         pulse_tick  = ($urandom % 5) < 2;
         r = $urandom % 100;
         op_done    = r < 6;
         wbuf_abort = (r >= 6) && (r < 12);
         cmd_reset        = ($urandom % 10) == 0;
         cmd_bypass_reset = ($urandom % 10) == 0;
         cmd_abort_reset  = ($urandom % 10) == 0;
         cyc("R5 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule